// File: doc/BRIEF.md
# Receive Fragment Ring Writer

This block sits behind a receive MAC and turns an incoming byte stream into a ring of fixed-size receive buffers held in system memory. Each stream beat has a valid, a data byte, a start marker, an end marker and an error marker. The block stores the bytes of a frame across as many buffers as the frame needs and updates the two-word descriptor that belongs to each buffer. It hands every filled buffer back to software by setting that descriptor's ownership flag.

The block keeps a descriptor pointer that starts at a programmable ring base. Before it uses a descriptor, it reads the descriptor's address word. A descriptor that software has not yet returned is left untouched, and the block reports that no buffer was available. The block also has two sticky status bits: one for a frame that completed and one for a missing buffer. Software clears these bits by writing ones. An interrupt output is the OR of the status bits that are enabled. Memory is reached through one request/grant port. This port carries word reads of descriptors, word writes of descriptors and byte writes of frame data.

Top module: `rx_frag_writer`

## Requirements
- R1: A frame is split into fragments of BUF_BYTES bytes. When a fragment is full and another byte is to be stored, that fragment is closed and the byte goes to the buffer of the next descriptor, at offset 0.
- R2: A closed fragment has its address word (descriptor offset 0) rewritten. Bit 0, the ownership flag, is set to 1. Bit 1, the wrap mark, is kept. Bits 31:2, the buffer address, are kept.
- R3: After the block closes a descriptor whose wrap bit is 1, or the descriptor at ring index DEPTH-1, it continues at the ring base. Otherwise it continues 8 bytes further on. Descriptor reads always fall inside the ring and are 8-byte aligned from the base.
- R4: The control word of a fragment (descriptor offset 4) is written as follows. Bit 30 is 1 only on the first fragment of a frame. Bit 31 is 1 only on its last fragment. Bits LEN_W-1:0 hold the stored frame length on the last fragment and 0 on every other fragment.
- R5: When a descriptor read returns ownership bit 1, the block sets status bit 1 (no buffer). It does not write that descriptor or its buffer, and it drops the rest of the frame. The pointer does not move.
- R6: Status bit 0 (frame done) is set the cycle after the address word of an end-of-frame fragment is granted, and at no other time.
- R7: With discardFcs high, the last 4 bytes of a frame are neither stored nor counted in the length. A frame of 4 bytes or fewer then stores nothing, writes no descriptor and does not set frame done.
- R8: An error beat ends the frame. If a fragment is open, it is closed with ownership set and the end flag clear. Frame done is not set.
- R9: When statusClrWe is high, each status bit whose statusClrData bit is 1 is cleared. A set in the same cycle wins over the clear. irq is the OR of status AND intEnable.
- R10: A rising edge on rxEnable reloads the pointer with ringBase. Beats are consumed and dropped while rxEnable is low, and also outside a frame when they lack the start marker.
- R11: A memory request holds its address, data and write flag steady until it is granted. Data writes carry a one-hot byte enable. Descriptor writes carry 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous release |
| rxEnable | input | 1 | Receive enable; rising edge reloads the pointer |
| discardFcs | input | 1 | Strip the trailing 4 bytes of each frame |
| ringBase | input | AW | Byte address of descriptor 0 |
| intEnable | input | 2 | Per-bit interrupt enable for status |
| statusClrWe | input | 1 | Write strobe for status clear |
| statusClrData | input | 2 | Write-one-to-clear mask |
| inValid | input | 1 | Stream beat present |
| inReady | output | 1 | Beat is taken on this edge |
| inData | input | 8 | Stream byte |
| inSof | input | 1 | First beat of a frame |
| inEof | input | 1 | Last beat of a frame |
| inErr | input | 1 | Beat aborts the frame; its byte is dropped |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | AW | Byte address |
| memWData | output | 32 | Write data |
| memBe | output | 4 | Byte enables for writes |
| memGnt | input | 1 | Request accepted this cycle |
| memRData | input | 32 | Read data, valid the cycle after a granted read |
| status | output | 2 | Bit 0 frame done, bit 1 no buffer |
| irq | output | 1 | Interrupt |

## Verification
The frame-done bit can be set in the same cycle that software writes a one to clear it. The bench arms a watcher on the memory port. In the exact cycle the end-of-frame address word is granted, the watcher drives the clear strobe for bit 0. The bench then requires that frame done still reads 1, and that the watcher really fired. A later plain clear must then drop the bit.

// File: rtl/rx_frag_pkg.sv
package rx_frag_pkg;
  localparam int OWN_BIT     = 0;
  localparam int WRAP_BIT    = 1;
  localparam int SOF_BIT     = 30;
  localparam int EOF_BIT     = 31;
  localparam int ST_DONE     = 0;
  localparam int ST_NOBUF    = 1;
  localparam int DESC_STRIDE = 8;
  localparam int HOLD_BYTES  = 4;

  typedef enum logic [2:0] {
    MS_NONE, MS_DESC_RD, MS_BYTE, MS_CTRL, MS_ADDR
  } memSel_e;

  typedef struct packed {
    memSel_e memSel;
    logic    acceptBeat;
    logic    startFrame;
    logic    latchDesc;
    logic    byteDone;
    logic    closeDone;
    logic    closeEof;
    logic    setDone;
    logic    setNoBuf;
  } strobe_t;
endpackage

// File: rtl/rx_frag_ctrl.sv
module rx_frag_ctrl
  import rx_frag_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxEnable,
  input  logic    inValid,
  input  logic    inSof,
  input  logic    inEof,
  input  logic    inErr,
  input  logic    memGnt,
  input  logic    commitIfStart,
  input  logic    commitIfCont,
  input  logic    fragOpen,
  input  logic    fragFull,
  input  logic    descOwned,
  output logic    inReady,
  output logic    memReq,
  output logic    memWe,
  output strobe_t st
);
  typedef enum logic [2:0] {
    S_ACCEPT, S_RDREQ, S_RDWAIT, S_WBYTE, S_CTRL, S_ADDR
  } state_e;
  typedef enum logic [1:0] {CL_CONT, CL_EOF, CL_ABORT} close_e;

  state_e state;
  close_e reason;
  logic   inFrame;
  logic   eofPend;
  logic   beatLive;
  logic   commit;

  always_comb begin
    st       = '0;
    inReady  = (state == S_ACCEPT);
    memReq   = (state == S_RDREQ) || (state == S_WBYTE) ||
               (state == S_CTRL)  || (state == S_ADDR);
    memWe    = (state != S_RDREQ);
    beatLive = inValid && (state == S_ACCEPT) && rxEnable &&
               (inFrame || inSof) && !inErr;
    commit   = inFrame ? commitIfCont : commitIfStart;
    unique case (state)
      S_RDREQ: st.memSel = MS_DESC_RD;
      S_WBYTE: st.memSel = MS_BYTE;
      S_CTRL:  st.memSel = MS_CTRL;
      S_ADDR:  st.memSel = MS_ADDR;
      default: st.memSel = MS_NONE;
    endcase
    st.acceptBeat = beatLive;
    st.startFrame = beatLive && !inFrame;
    st.latchDesc  = (state == S_RDWAIT) && !descOwned;
    st.setNoBuf   = (state == S_RDWAIT) && descOwned;
    st.byteDone   = (state == S_WBYTE) && memGnt;
    st.closeDone  = (state == S_ADDR) && memGnt;
    st.closeEof   = (reason == CL_EOF);
    st.setDone    = (state == S_ADDR) && memGnt && (reason == CL_EOF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_ACCEPT;
      reason  <= CL_CONT;
      inFrame <= 1'b0;
      eofPend <= 1'b0;
    end else begin
      unique case (state)
        S_ACCEPT: begin
          if (!rxEnable) begin
            inFrame <= 1'b0;
          end else if (inValid) begin
            if (inErr) begin
              if (inFrame && fragOpen) begin
                reason <= CL_ABORT;
                state  <= S_CTRL;
              end
              inFrame <= 1'b0;
            end else if (inFrame || inSof) begin
              inFrame <= 1'b1;
              eofPend <= inEof;
              if (commit) begin
                if (!fragOpen || !inFrame) begin
                  state <= S_RDREQ;
                end else if (fragFull) begin
                  reason <= CL_CONT;
                  state  <= S_CTRL;
                end else begin
                  state <= S_WBYTE;
                end
              end else if (inEof) begin
                if (fragOpen && inFrame) begin
                  reason <= CL_EOF;
                  state  <= S_CTRL;
                end else begin
                  inFrame <= 1'b0;
                end
              end
            end
          end
        end
        S_RDREQ: if (memGnt) state <= S_RDWAIT;
        S_RDWAIT: begin
          if (descOwned) begin
            inFrame <= 1'b0;
            state   <= S_ACCEPT;
          end else begin
            state <= S_WBYTE;
          end
        end
        S_WBYTE: begin
          if (memGnt) begin
            if (eofPend) begin
              reason <= CL_EOF;
              state  <= S_CTRL;
            end else begin
              state <= S_ACCEPT;
            end
          end
        end
        S_CTRL: if (memGnt) state <= S_ADDR;
        S_ADDR: begin
          if (memGnt) begin
            unique case (reason)
              CL_CONT: state <= S_RDREQ;
              CL_EOF: begin
                inFrame <= 1'b0;
                state   <= S_ACCEPT;
              end
              default: state <= S_ACCEPT;
            endcase
          end
        end
        default: state <= S_ACCEPT;
      endcase
    end
  end
endmodule

// File: rtl/rx_frag_path.sv
module rx_frag_path
  import rx_frag_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DEPTH     = 512,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic          rxEnable,
  input  logic          discardFcs,
  input  logic [AW-1:0] ringBase,
  input  logic [1:0]    intEnable,
  input  logic          statusClrWe,
  input  logic [1:0]    statusClrData,
  input  logic [7:0]    inData,
  input  logic [31:0]   memRData,
  output logic          commitIfStart,
  output logic          commitIfCont,
  output logic          fragOpen,
  output logic          fragFull,
  output logic          descOwned,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWData,
  output logic [3:0]    memBe,
  output logic [1:0]    status,
  output logic          irq
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(BUF_BYTES) + 1;
  localparam int HC_W  = $clog2(HOLD_BYTES) + 1;

  logic [HOLD_BYTES-1:0][7:0] hold;
  logic [HC_W-1:0]  holdCnt;
  logic [HC_W-1:0]  effCnt;
  logic             holdFull;
  logic             commitNow;
  logic [7:0]       pendByte;
  logic [LEN_W-1:0] frameLen;
  logic             firstFrag;
  logic [31:0]      descWord;
  logic             wrapBit;
  logic [CNT_W-1:0] fragCnt;
  logic [AW-1:0]    descPtr;
  logic [IDX_W-1:0] descIdx;
  logic             enPrev;
  logic             enRise;
  logic [AW-1:0]    byteAddr;
  logic [1:0]       setVec;

  assign effCnt        = st.startFrame ? '0 : holdCnt;
  assign holdFull      = (effCnt == HC_W'(HOLD_BYTES));
  assign commitNow     = !discardFcs || holdFull;
  assign commitIfStart = !discardFcs;
  assign commitIfCont  = !discardFcs || (holdCnt == HC_W'(HOLD_BYTES));
  assign fragFull      = (fragCnt == CNT_W'(BUF_BYTES));
  assign descOwned     = memRData[OWN_BIT];
  assign enRise        = rxEnable && !enPrev;
  assign byteAddr      = descWord[AW-1:0] + AW'(fragCnt);

  // Byte hold-back line and frame length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hold     <= '0;
      holdCnt  <= '0;
      pendByte <= '0;
      frameLen <= '0;
    end else if (st.acceptBeat) begin
      frameLen <= (st.startFrame ? '0 : frameLen) + LEN_W'(commitNow);
      if (discardFcs) begin
        if (holdFull) pendByte <= hold[HOLD_BYTES-1];
        hold    <= {hold[HOLD_BYTES-2:0], inData};
        holdCnt <= holdFull ? effCnt : effCnt + 1'b1;
      end else begin
        pendByte <= inData;
        holdCnt  <= '0;
      end
    end
  end

  // Open fragment and ring pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev    <= 1'b0;
      fragOpen  <= 1'b0;
      firstFrag <= 1'b0;
      descWord  <= '0;
      wrapBit   <= 1'b0;
      fragCnt   <= '0;
      descPtr   <= '0;
      descIdx   <= '0;
    end else begin
      enPrev <= rxEnable;
      if (st.startFrame) begin
        firstFrag <= 1'b1;
        fragOpen  <= 1'b0;
      end
      if (st.latchDesc) begin
        descWord <= {memRData[31:2], 2'b00};
        wrapBit  <= memRData[WRAP_BIT];
        fragCnt  <= '0;
        fragOpen <= 1'b1;
      end
      if (st.byteDone) fragCnt <= fragCnt + 1'b1;
      if (st.closeDone) begin
        fragOpen  <= 1'b0;
        firstFrag <= 1'b0;
        if (wrapBit || descIdx == IDX_W'(DEPTH - 1)) begin
          descPtr <= ringBase;
          descIdx <= '0;
        end else begin
          descPtr <= descPtr + AW'(DESC_STRIDE);
          descIdx <= descIdx + 1'b1;
        end
      end
      if (enRise) begin
        descPtr  <= ringBase;
        descIdx  <= '0;
        fragOpen <= 1'b0;
      end
    end
  end

  // Memory port formatting
  always_comb begin
    memAddr  = descPtr;
    memWData = '0;
    memBe    = 4'hF;
    unique case (st.memSel)
      MS_BYTE: begin
        memAddr  = byteAddr;
        memWData = {4{pendByte}};
        memBe    = 4'b0001 << byteAddr[1:0];
      end
      MS_CTRL: begin
        memAddr                = descPtr + AW'(4);
        memWData[EOF_BIT]      = st.closeEof;
        memWData[SOF_BIT]      = firstFrag;
        memWData[LEN_W-1:0]    = st.closeEof ? frameLen : '0;
      end
      MS_ADDR: begin
        memWData           = descWord;
        memWData[WRAP_BIT] = wrapBit;
        memWData[OWN_BIT]  = 1'b1;
      end
      default: ;
    endcase
  end

  // Sticky status, set over clear
  assign setVec = {st.setNoBuf, st.setDone};
  for (genvar b = 0; b < 2; b++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN) status[b] <= 1'b0;
      else status[b] <= setVec[b] ||
                        (status[b] && !(statusClrWe && statusClrData[b]));
    end
  end
  assign irq = |(status & intEnable);
endmodule

// File: rtl/rx_frag_writer.sv
module rx_frag_writer
  import rx_frag_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DEPTH     = 512,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxEnable,
  input  logic          discardFcs,
  input  logic [AW-1:0] ringBase,
  input  logic [1:0]    intEnable,
  input  logic          statusClrWe,
  input  logic [1:0]    statusClrData,
  input  logic          inValid,
  output logic          inReady,
  input  logic [7:0]    inData,
  input  logic          inSof,
  input  logic          inEof,
  input  logic          inErr,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWData,
  output logic [3:0]    memBe,
  input  logic          memGnt,
  input  logic [31:0]   memRData,
  output logic [1:0]    status,
  output logic          irq
);
  strobe_t st;
  logic    commitIfStart;
  logic    commitIfCont;
  logic    fragOpen;
  logic    fragFull;
  logic    descOwned;

  rx_frag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable),
    .inValid(inValid), .inSof(inSof), .inEof(inEof), .inErr(inErr),
    .memGnt(memGnt), .commitIfStart(commitIfStart),
    .commitIfCont(commitIfCont), .fragOpen(fragOpen),
    .fragFull(fragFull), .descOwned(descOwned),
    .inReady(inReady), .memReq(memReq), .memWe(memWe), .st(st)
  );

  rx_frag_path #(
    .AW(AW), .DEPTH(DEPTH), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .st(st), .rxEnable(rxEnable),
    .discardFcs(discardFcs), .ringBase(ringBase), .intEnable(intEnable),
    .statusClrWe(statusClrWe), .statusClrData(statusClrData),
    .inData(inData), .memRData(memRData),
    .commitIfStart(commitIfStart), .commitIfCont(commitIfCont),
    .fragOpen(fragOpen), .fragFull(fragFull), .descOwned(descOwned),
    .memAddr(memAddr), .memWData(memWData), .memBe(memBe),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/rx_frag_checker.sv
module rx_frag_checker #(
  parameter int AW    = 32,
  parameter int DEPTH = 512
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] ringBase,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [31:0]   memWData,
  input logic [3:0]    memBe,
  input logic          memGnt,
  input logic [31:0]   memRData,
  input logic [1:0]    status
);
  localparam logic [AW-1:0] RING_SPAN = AW'(DEPTH * 8);
  logic [AW-1:0] ringOff;
  assign ringOff = memAddr - ringBase;

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) &&
                          $stable(memWData) && $stable(memWe));

  assert_be_shape_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> (memBe == 4'hF) || $onehot(memBe));

  assert_read_in_ring_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> (ringOff < RING_SPAN) && (ringOff[2:0] == 3'd0));

  assert_done_after_close_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> $past(memReq && memGnt && memWe &&
                               memBe == 4'hF && memWData[0]));

  assert_nobuf_after_owned_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1]) |-> $past(!memReq) && $past(memRData[0]));
endmodule

bind rx_frag_writer rx_frag_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_frag_writer_bench.sv
module rx_frag_writer_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 8, DEPTH = 4, BUF = 8, LEN_W = 16;
  localparam int BUF_BASE = 64, BUF_STRIDE = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, rxEnable, discardFcs, statusClrWe, inValid, inReady;
  logic inSof, inEof, inErr, memReq, memWe, memGnt, irq;
  logic [AW-1:0] ringBase, memAddr;
  logic [1:0] intEnable, statusClrData, status;
  logic [7:0] inData;
  logic [31:0] memWData, memRData;
  logic [3:0] memBe;

  logic manClrWe;
  logic [1:0] manClrData;
  logic armClr, coincide, hitCoincide;
  logic [AW-1:0] armAddr;
  logic stall;
  int gcnt;

  logic [7:0] mem [256];
  int nChk = 0, nBad = 0;
  bit finished = 0;

  rx_frag_writer #(.AW(AW), .DEPTH(DEPTH), .BUF_BYTES(BUF), .LEN_W(LEN_W)) u_rx_frag_writer (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .discardFcs(discardFcs),
    .ringBase(ringBase), .intEnable(intEnable), .statusClrWe(statusClrWe),
    .statusClrData(statusClrData), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSof(inSof), .inEof(inEof), .inErr(inErr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memBe(memBe), .memGnt(memGnt), .memRData(memRData),
    .status(status), .irq(irq));

  assign memGnt = memReq && !stall;
  assign coincide = armClr && memReq && memGnt && memWe && memBe == 4'hF &&
                    memAddr == armAddr && memWData[0];
  assign statusClrWe = manClrWe || coincide;
  assign statusClrData = coincide ? 2'b01 : manClrData;

  always @(negedge clk) begin
    gcnt  <= gcnt + 1;
    stall <= (gcnt % 3 == 2);
  end

  always @(posedge clk) begin
    if (coincide) hitCoincide <= 1'b1;
    if (memReq && memGnt) begin
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[{memAddr[7:2], 2'(b)}] <= memWData[8*b +: 8];
      end else begin
        memRData <= {mem[{memAddr[7:2], 2'd3}], mem[{memAddr[7:2], 2'd2}],
                     mem[{memAddr[7:2], 2'd1}], mem[{memAddr[7:2], 2'd0}]};
      end
    end
  end

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  function automatic logic [7:0] pat(input int base, input int i);
    return 8'((base * 7 + i * 3 + 1) & 255);
  endfunction

  function automatic logic [31:0] expAddr(input int idx);
    return 32'(BUF_BASE + idx * BUF_STRIDE) | (idx == DEPTH - 1 ? 32'd2 : 32'd0) | 32'd1;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic initRing();
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] w;
      w = expAddr(i) & ~32'd1;
      for (int b = 0; b < 4; b++) begin
        mem[i*8 + b]     = w[8*b +: 8];
        mem[i*8 + 4 + b] = 8'h00;
      end
      for (int j = 0; j < BUF_STRIDE; j++) mem[BUF_BASE + i*BUF_STRIDE + j] = 8'hEE;
    end
  endtask

  task automatic sendBeat(input logic [7:0] d, input logic s, input logic e, input logic r);
    logic rdyNow;
    inValid = 1'b1; inData = d; inSof = s; inEof = e; inErr = r;
    while (1) begin
      rdyNow = inReady;
      @(negedge clk);
      if (rdyNow) break;
    end
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; inErr = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic sendFrame(input int n, input int base, input int errAt);
    for (int i = 0; i < n; i++)
      sendBeat(pat(base, i), i == 0, (i == n - 1) && errAt < 0, i == errAt);
    settle();
  endtask

  task automatic clearStatus(input logic [1:0] m);
    manClrWe = 1'b1; manClrData = m;
    @(negedge clk);
    manClrWe = 1'b0; manClrData = 2'b00;
    @(negedge clk);
  endtask

  // Checks every fragment of a completed frame; returns the next ring index
  task automatic checkFrame(input int S, input int startIdx, input int base,
                            input string tag, output int nextIdx);
    int n;
    n = (S + BUF - 1) / BUF;
    for (int k = 0; k < n; k++) begin
      int idx, fl;
      logic [31:0] ec;
      idx = (startIdx + k) % DEPTH;
      fl = (k == n - 1) ? S - k * BUF : BUF;
      ec = ((k == n - 1) ? 32'h8000_0000 | 32'(S) : 32'd0) | ((k == 0) ? 32'h4000_0000 : 32'd0);
      check(rd32(idx*8) == expAddr(idx), {tag, " R2 addr word"}, rd32(idx*8), expAddr(idx));
      check(rd32(idx*8+4) == ec, {tag, " R4 ctrl word"}, rd32(idx*8+4), ec);
      for (int j = 0; j < fl; j++)
        check(mem[BUF_BASE + idx*BUF_STRIDE + j] == pat(base, k*BUF + j), {tag, " R1 data"},
              mem[BUF_BASE + idx*BUF_STRIDE + j], pat(base, k*BUF + j));
    end
    nextIdx = (startIdx + n) % DEPTH;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int ptr, S, base;
    rstN = 0; rxEnable = 0; discardFcs = 0; ringBase = '0; intEnable = 2'b11;
    manClrWe = 0; manClrData = 0; armClr = 0; armAddr = '0; hitCoincide = 0;
    inValid = 0; inData = 0; inSof = 0; inEof = 0; inErr = 0; gcnt = 0; stall = 0;
    memRData = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(status == 2'b00, "R9 reset status", status, 0);
    check(irq == 1'b0, "R9 reset irq", irq, 0);
    check(memReq == 1'b0, "R11 reset idle port", memReq, 0);
    check(inReady == 1'b1, "R10 reset ready", inReady, 1);
    rxEnable = 1;
    repeat (2) @(negedge clk);

    // Sweep of lengths with and without FCS stripping (R1 R4 R6 R7)
    ptr = 0; base = 0;
    for (int d = 0; d < 2; d++) begin
      discardFcs = d[0];
      for (int L = 1; L <= 20; L++) begin
        initRing();
        clearStatus(2'b11);
        base++;
        sendFrame(L, base, -1);
        S = d ? ((L > 4) ? L - 4 : 0) : L;
        checkFrame(S, ptr, base, "R7 sweep", ptr);
        check(status[0] == (S > 0), "R6 done flag", status[0], S > 0);
        check(status[1] == 1'b0, "R5 no spurious nobuf", status[1], 0);
        if (S == 0)
          check(rd32(ptr*8) == (expAddr(ptr) & ~32'd1), "R7 empty frame untouched",
                rd32(ptr*8), expAddr(ptr) & ~32'd1);
      end
    end

    // Interrupt enable and write-one-to-clear (R9)
    intEnable = 2'b10; #1;
    check(irq == 1'b0, "R9 masked irq", irq, 0);
    intEnable = 2'b01; #1;
    check(irq == 1'b1, "R9 enabled irq", irq, 1);
    clearStatus(2'b10);
    check(status[0] == 1'b1, "R9 clear other bit keeps done", status[0], 1);
    clearStatus(2'b01);
    check(status == 2'b00, "R9 clear done", status, 0);
    check(irq == 1'b0, "R9 irq after clear", irq, 0);
    intEnable = 2'b11;
    discardFcs = 0;

    // Disabled beats dropped, re-enable reloads base (R10)
    initRing();
    rxEnable = 0;
    @(negedge clk);
    base++;
    sendFrame(5, base, -1);
    check(rd32(ptr*8) == (expAddr(ptr) & ~32'd1), "R10 disabled frame dropped",
          rd32(ptr*8), expAddr(ptr) & ~32'd1);
    rxEnable = 1;
    repeat (2) @(negedge clk);
    base++;
    sendFrame(3, base, -1);
    checkFrame(3, 0, base, "R10 reload base", ptr);
    check(ptr == 1, "R10 pointer", ptr, 1);
    sendBeat(8'h55, 0, 0, 0);
    sendBeat(8'h56, 0, 1, 0);
    base++;
    sendFrame(2, base, -1);
    checkFrame(2, 1, base, "R10 stray beats dropped", ptr);
    check(rd32(2*8) == (expAddr(2) & ~32'd1), "R10 next desc free", rd32(16), expAddr(2) & ~32'd1);

    // Error mid-frame: partial fragments, no end flag (R8)
    initRing();
    clearStatus(2'b11);
    base++;
    sendFrame(11, base, 10);
    check(rd32(2*8+4) == 32'h4000_0000, "R8 first frag sof only", rd32(20), 32'h4000_0000);
    check(rd32(3*8+4) == 32'h0, "R8 second frag no eof", rd32(28), 0);
    check(rd32(3*8) == expAddr(3), "R8 owner set on abort", rd32(24), expAddr(3));
    check(mem[BUF_BASE + 3*BUF_STRIDE + 1] == pat(base, 9), "R8 partial data",
          mem[BUF_BASE + 3*BUF_STRIDE + 1], pat(base, 9));
    check(mem[BUF_BASE + 3*BUF_STRIDE + 2] == 8'hEE, "R8 error byte not stored",
          mem[BUF_BASE + 3*BUF_STRIDE + 2], 8'hEE);
    check(status == 2'b00, "R8 no done", status, 0);

    // Ring exhausted: owned descriptor untouched (R5, R3 wrap)
    initRing();
    clearStatus(2'b11);
    base++;
    sendFrame(40, base, -1);
    check(status == 2'b10, "R5 nobuf only", status, 2'b10);
    check(mem[BUF_BASE] == pat(base, 0), "R5 buffer not overwritten", mem[BUF_BASE], pat(base, 0));
    check(rd32(4) == 32'h4000_0000, "R5 owned ctrl untouched", rd32(4), 32'h4000_0000);
    check(rd32(3*8+4) == 32'h0, "R3 wrap frag no eof", rd32(28), 0);
    check(rd32(3*8) == expAddr(3), "R3 wrap desc owned", rd32(24), expAddr(3));
    initRing();
    clearStatus(2'b11);
    base++;
    sendFrame(3, base, -1);
    checkFrame(3, 0, base, "R5 pointer held", ptr);

    // Same-cycle set and clear of done (R9, R6)
    initRing();
    clearStatus(2'b11);
    armAddr = AW'(ptr * 8); armClr = 1; hitCoincide = 0;
    base++;
    sendFrame(3, base, -1);
    armClr = 0;
    check(hitCoincide == 1'b1, "R9 coincide provoked", hitCoincide, 1);
    check(status[0] == 1'b1, "R9 set wins over clear", status[0], 1);
    clearStatus(2'b01);
    check(status[0] == 1'b0, "R9 later clear", status[0], 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule